// File: doc/BRIEF.md
# Start offset splitter

This block turns a linear frame-buffer start address into panning values that a display timing engine can use directly. From a raw start-offset register, a raw pitch register and a pixel-depth code, it derives the visible line width in pixels and the line stride in bytes. It then reports the start position as a whole number of lines (Y) plus a pixel column within that line (X).

A start pulse captures the three register values. A single restoring divider, shared between two passes, does the work. The first pass divides the masked offset by the byte stride. When that pass leaves a remainder, a second pass divides the remainder by the bytes per pixel and raises a misalignment flag. Results appear together with a one-cycle done pulse.

A pitch field of zero leaves every result as it was. An unsupported depth code clears all results and raises an error flag.

Top module: `pan_split`

## Requirements
- R1: Only the low 27 bits of `offset_i` take part in the computation; the upper bits have no effect on any result.
- R2: `vwidth_o` equals the low 11 bits of `pitch_i` multiplied by 8. The upper bits of `pitch_i` are ignored.
- R3: The depth code on `depth_i` selects the bit depth: 0→8, 1→15, 2→16, 3→24, 4→32. Bytes per pixel is the bit depth divided by 8, rounded up (1, 2, 2, 3, 4). The byte stride is `vwidth_o` times bytes per pixel.
- R4: `yoff_o` is the masked offset divided by the byte stride, truncated.
- R5: When the offset is a whole multiple of the byte stride, `xoff_o` is 0 and `misalign_o` is 0.
- R6: When the remainder of that division is nonzero, `xoff_o` is the remainder divided by bytes per pixel (truncated) and `misalign_o` is 1.
- R7: When the low 11 bits of `pitch_i` are zero and the depth code is valid, `done_o` still pulses and every result output keeps its previous value.
- R8: A depth code of 5, 6 or 7 drives `vwidth_o`, `xoff_o`, `yoff_o` and `misalign_o` to 0 and sets `err_o` to 1. The next valid computation clears `err_o`.
- R9: `done_o` is high for exactly one cycle per accepted start. `busy_o` is high from the cycle after the start until that cycle, and low while `done_o` is high.
- R10: A start pulse arriving while `busy_o` is high is ignored. It does not change the result in progress and produces no extra `done_o`. Result outputs stay stable while busy.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture inputs and begin a computation (accepted when idle) |
| offset_i | input | 32 | Raw start-offset register value in bytes |
| pitch_i | input | 32 | Raw pitch register value, in units of 8 pixels |
| depth_i | input | 3 | Pixel-depth code |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse, results valid |
| vwidth_o | output | 14 | Virtual line width in pixels |
| xoff_o | output | 14 | Horizontal pixel offset within the start line |
| yoff_o | output | 27 | Vertical offset in lines |
| misalign_o | output | 1 | Offset was not a whole multiple of the byte stride |
| err_o | output | 1 | Last request used an unsupported depth code |

## Verification
The bench targets the 24-bit depth, where the remainder is not a multiple of the 3-byte pixel. A design that skips the second division, or divides by the bit depth instead, reports a wrong column there. A design that forgets the 27-bit mask returns huge line counts when the upper offset bits are set. A design that does not multiply the stride by bytes per pixel gives wrong Y values for every depth above 8.

The bench also tries a pitch register whose only set bits lie above the field. A design that masks wrongly, or that updates results on a zero pitch, loses the previous panning values. A second start during a computation is checked as well: a design that accepts it would finish with the second operands or pulse done twice.

// File: rtl/pan_pkg.sv
package pan_pkg;
  localparam int REG_W = 32;
  localparam int DEP_W = 3;
  localparam int BPP_W = 3;

  typedef enum logic [1:0] {S_IDLE, S_YDIV, S_XDIV, S_END} pan_st_e;

  // bits per pixel for a depth code; 0 marks an unsupported code
  function automatic logic [5:0] depth_bits(input logic [DEP_W-1:0] code);
    case (code)
      3'd0:    return 6'd8;
      3'd1:    return 6'd15;
      3'd2:    return 6'd16;
      3'd3:    return 6'd24;
      3'd4:    return 6'd32;
      default: return 6'd0;
    endcase
  endfunction
endpackage

// File: rtl/pan_decode.sv
module pan_decode
  import pan_pkg::*;
#(
  parameter int OFS_W = 27,
  parameter int PIT_W = 11,
  localparam int PIX_W = PIT_W + 3,
  localparam int STR_W = PIX_W + 2
) (
  input  logic [REG_W-1:0] offset_i,
  input  logic [REG_W-1:0] pitch_i,
  input  logic [DEP_W-1:0] depth_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic [PIX_W-1:0] pix_o,
  output logic [BPP_W-1:0] bpp_o,
  output logic [STR_W-1:0] stride_o,
  output logic             valid_o,
  output logic             zero_o
);
  logic [5:0] bits;
  logic [6:0] bits_rnd;
  logic       unused_hi;

  assign unused_hi = ^{offset_i[REG_W-1:OFS_W], pitch_i[REG_W-1:PIT_W]};

  always_comb begin
    bits     = depth_bits(depth_i);
    bits_rnd = {1'b0, bits} + 7'd7;
    ofs_o    = offset_i[OFS_W-1:0];
    pix_o    = {pitch_i[PIT_W-1:0], 3'b000};
    bpp_o    = bits_rnd[5:3];
    stride_o = STR_W'(pix_o) * STR_W'(bpp_o);
    valid_o  = (bits != 6'd0);
    zero_o   = (pitch_i[PIT_W-1:0] == '0);
  end
endmodule

// File: rtl/pan_div.sv
module pan_div #(
  parameter int NW = 27,
  parameter int DW = 16,
  localparam int CW = $clog2(NW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          done_o,
  output logic [NW-1:0] quot_o,
  output logic [DW-1:0] rem_o
);
  logic [NW-1:0] q_q;
  logic [DW-1:0] r_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [DW:0]   trial, diff;
  logic          take;

  always_comb begin
    trial = {r_q, q_q[NW-1]};
    diff  = trial - {1'b0, den_q};
    take  = (trial >= {1'b0, den_q});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      r_q    <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        q_q   <= num_i;
        r_q   <= '0;
        den_q <= den_i;
        cnt_q <= CW'(NW);
        run_q <= 1'b1;
      end else if (run_q) begin
        q_q   <= {q_q[NW-2:0], take};
        r_q   <= take ? diff[DW-1:0] : trial[DW-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = q_q;
  assign rem_o  = r_q;
endmodule

// File: rtl/pan_split.sv
module pan_split
  import pan_pkg::*;
#(
  parameter int OFS_W = 27,
  parameter int PIT_W = 11,
  localparam int PIX_W = PIT_W + 3,
  localparam int STR_W = PIX_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [REG_W-1:0] offset_i,
  input  logic [REG_W-1:0] pitch_i,
  input  logic [DEP_W-1:0] depth_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [PIX_W-1:0] vwidth_o,
  output logic [PIX_W-1:0] xoff_o,
  output logic [OFS_W-1:0] yoff_o,
  output logic             misalign_o,
  output logic             err_o
);
  logic [OFS_W-1:0] d_ofs;
  logic [PIX_W-1:0] d_pix;
  logic [BPP_W-1:0] d_bpp;
  logic [STR_W-1:0] d_stride;
  logic             d_valid, d_zero;

  pan_decode #(.OFS_W(OFS_W), .PIT_W(PIT_W)) u_dec (
    .offset_i (offset_i),
    .pitch_i  (pitch_i),
    .depth_i  (depth_i),
    .ofs_o    (d_ofs),
    .pix_o    (d_pix),
    .bpp_o    (d_bpp),
    .stride_o (d_stride),
    .valid_o  (d_valid),
    .zero_o   (d_zero)
  );

  pan_st_e          st_q;
  logic             go_q;
  logic [OFS_W-1:0] num_q;
  logic [STR_W-1:0] den_q;
  logic [PIX_W-1:0] pix_q;
  logic [BPP_W-1:0] bpp_q;
  logic [OFS_W-1:0] yq_q;
  logic             bad_q;
  logic             div_done;
  logic [OFS_W-1:0] div_quot;
  logic [STR_W-1:0] div_rem;
  logic             unused_quot;

  assign unused_quot = ^div_quot[OFS_W-1:PIX_W];

  pan_div #(.NW(OFS_W), .DW(STR_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go_q),
    .num_i  (num_q),
    .den_i  (den_q),
    .done_o (div_done),
    .quot_o (div_quot),
    .rem_o  (div_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      go_q       <= 1'b0;
      num_q      <= '0;
      den_q      <= '0;
      pix_q      <= '0;
      bpp_q      <= '0;
      yq_q       <= '0;
      bad_q      <= 1'b0;
      done_o     <= 1'b0;
      vwidth_o   <= '0;
      xoff_o     <= '0;
      yoff_o     <= '0;
      misalign_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_o <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          pix_q <= d_pix;
          bpp_q <= d_bpp;
          bad_q <= !d_valid;
          if (!d_valid || d_zero) begin
            st_q <= S_END;
          end else begin
            num_q <= d_ofs;
            den_q <= d_stride;
            go_q  <= 1'b1;
            st_q  <= S_YDIV;
          end
        end
        S_YDIV: if (div_done) begin
          if (div_rem == '0) begin
            yoff_o     <= div_quot;
            xoff_o     <= '0;
            misalign_o <= 1'b0;
            vwidth_o   <= pix_q;
            err_o      <= 1'b0;
            done_o     <= 1'b1;
            st_q       <= S_IDLE;
          end else begin
            // second pass: remainder bytes to pixels
            yq_q  <= div_quot;
            num_q <= OFS_W'(div_rem);
            den_q <= STR_W'(bpp_q);
            go_q  <= 1'b1;
            st_q  <= S_XDIV;
          end
        end
        S_XDIV: if (div_done) begin
          yoff_o     <= yq_q;
          xoff_o     <= div_quot[PIX_W-1:0];
          misalign_o <= 1'b1;
          vwidth_o   <= pix_q;
          err_o      <= 1'b0;
          done_o     <= 1'b1;
          st_q       <= S_IDLE;
        end
        default: begin
          if (bad_q) begin
            yoff_o     <= '0;
            xoff_o     <= '0;
            misalign_o <= 1'b0;
            vwidth_o   <= '0;
            err_o      <= 1'b1;
          end
          done_o <= 1'b1;
          st_q   <= S_IDLE;
        end
      endcase
    end
  end

  assign busy_o = (st_q != S_IDLE);
endmodule

// File: rtl/pan_split_chk.sv
module pan_split_chk #(
  parameter int OFS_W = 27,
  parameter int PIX_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             done_o,
  input logic [PIX_W-1:0] vwidth_o,
  input logic [PIX_W-1:0] xoff_o,
  input logic [OFS_W-1:0] yoff_o,
  input logic             misalign_o,
  input logic             err_o
);
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r9_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
  a_r8_err_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (vwidth_o == '0 && xoff_o == '0 && yoff_o == '0 && !misalign_o));
  a_r5_aligned_no_x: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !misalign_o |-> (xoff_o == '0));
  a_r6_x_in_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (xoff_o < vwidth_o));
  a_r10_stable_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(yoff_o) && $stable(xoff_o) &&
                                   $stable(vwidth_o) && $stable(err_o)));
endmodule

bind pan_split pan_split_chk #(.OFS_W(OFS_W), .PIX_W(PIX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .vwidth_o   (vwidth_o),
  .xoff_o     (xoff_o),
  .yoff_o     (yoff_o),
  .misalign_o (misalign_o),
  .err_o      (err_o)
);

// File: tb/sim_pan_split.sv
module sim_pan_split;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] offset_i = '0;
  logic [31:0] pitch_i = '0;
  logic [2:0]  depth_i = '0;
  logic        busy_o, done_o, misalign_o, err_o;
  logic [13:0] vwidth_o, xoff_o;
  logic [26:0] yoff_o;

  int errors = 0;
  int checks = 0;
  bit ended = 0;

  always #2 clk_i = ~clk_i;

  pan_split u0 (.*);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int bytes_pp(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 2;
      3: return 3;
      4: return 4;
      default: return 0;
    endcase
  endfunction

  // pulse start, wait for done; returns 1 if done seen
  task automatic launch(input logic [31:0] ofs, input logic [31:0] pit, input logic [2:0] dep,
                        output bit seen);
    seen = 0;
    @(negedge clk_i);
    offset_i = ofs; pitch_i = pit; depth_i = dep; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done_o) begin seen = 1; break; end
      @(negedge clk_i);
    end
  endtask

  task automatic run_check(input string req, input logic [31:0] ofs, input logic [31:0] pit,
                           input logic [2:0] dep);
    bit seen;
    longint o, pw, bp, st, y, r;
    o  = longint'(ofs & 32'h07ff_ffff);
    pw = longint'(pit & 32'h7ff) * 8;
    bp = bytes_pp(int'(dep));
    st = pw * bp;
    y  = o / st;
    r  = o % st;
    launch(ofs, pit, dep, seen);
    chk(req, "done seen", seen, 1);
    chk(req, "yoff", yoff_o, y);
    chk(req, "xoff", xoff_o, (r != 0) ? r / bp : 0);
    chk(req, "misalign", misalign_o, (r != 0) ? 1 : 0);
    chk(req, "vwidth", vwidth_o, pw);
    chk(req, "err", err_o, 0);
    @(negedge clk_i);
    chk("R9", "done single cycle", done_o, 0);
  endtask

  task automatic t_reset;
    chk("R11", "busy", busy_o, 0);
    chk("R11", "done", done_o, 0);
    chk("R11", "vwidth", vwidth_o, 0);
    chk("R11", "xoff", xoff_o, 0);
    chk("R11", "yoff", yoff_o, 0);
    chk("R11", "misalign", misalign_o, 0);
    chk("R11", "err", err_o, 0);
  endtask

  task automatic t_aligned;   // R4 R5 R2
    run_check("R5", 32'd640, 32'd10, 3'd0);
    chk("R4", "aligned yoff 8", yoff_o, 8);
  endtask

  task automatic t_mask;      // R1
    run_check("R1", 32'hF800_0280, 32'd10, 3'd0);
    chk("R1", "masked yoff", yoff_o, 8);
  endtask

  task automatic t_depths;    // R3 R6
    run_check("R6", 32'd1000, 32'd10, 3'd4);
    chk("R6", "32bpp xoff", xoff_o, 10);
    run_check("R3", 32'd1000, 32'd10, 3'd3);
    chk("R3", "24bpp truncated xoff", xoff_o, 13);
    run_check("R3", 32'd1000, 32'd10, 3'd1);
    chk("R3", "15bpp xoff", xoff_o, 20);
    run_check("R3", 32'd1000, 32'd10, 3'd2);
    run_check("R4", 32'h07FF_FFFF, 32'h7FF, 3'd4);
    run_check("R2", 32'd4096, 32'hFFFF_F801, 3'd0);
    chk("R2", "upper pitch bits ignored", vwidth_o, 8);
  endtask

  task automatic t_pitch_zero;  // R7
    bit seen;
    logic [13:0] pv, px;
    logic [26:0] py;
    logic pm;
    run_check("R7", 32'd1000, 32'd10, 3'd3);
    pv = vwidth_o; px = xoff_o; py = yoff_o; pm = misalign_o;
    launch(32'd12345, 32'hFFFF_F800, 3'd0, seen);
    chk("R7", "done on zero pitch", seen, 1);
    chk("R7", "vwidth held", vwidth_o, pv);
    chk("R7", "xoff held", xoff_o, px);
    chk("R7", "yoff held", yoff_o, py);
    chk("R7", "misalign held", misalign_o, pm);
    chk("R7", "err", err_o, 0);
  endtask

  task automatic t_bad_depth;   // R8
    bit seen;
    launch(32'd1000, 32'd10, 3'd6, seen);
    chk("R8", "done", seen, 1);
    chk("R8", "err set", err_o, 1);
    chk("R8", "vwidth zero", vwidth_o, 0);
    chk("R8", "xoff zero", xoff_o, 0);
    chk("R8", "yoff zero", yoff_o, 0);
    chk("R8", "misalign zero", misalign_o, 0);
    run_check("R8", 32'd640, 32'd10, 3'd0);
  endtask

  task automatic t_busy_start;  // R10
    int extra;
    bit seen;
    @(negedge clk_i);
    offset_i = 32'd1000; pitch_i = 32'd10; depth_i = 3'd3; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    chk("R10", "busy during run", busy_o, 1);
    offset_i = 32'd640; pitch_i = 32'd20; depth_i = 3'd0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      if (done_o) begin seen = 1; break; end
      @(negedge clk_i);
    end
    chk("R10", "first run done", seen, 1);
    chk("R10", "yoff from first", yoff_o, 4);
    chk("R10", "xoff from first", xoff_o, 13);
    chk("R10", "vwidth from first", vwidth_o, 80);
    extra = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk_i);
      if (done_o) extra++;
    end
    chk("R10", "no extra done", extra, 0);
    chk("R10", "idle after", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_aligned();
    t_mask();
    t_depths();
    t_pitch_zero();
    t_bad_depth();
    t_busy_start();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!ended) begin
      ended = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule